// File: doc/BRIEF.md
# I2C Slave Address-Match Receiver

This block listens on an I2C bus as a receive-only slave. A fast system clock oversamples the SCL and SDA lines. The block finds Start, Repeated Start and Stop conditions and shifts in the bytes that follow. It compares the first byte, or the first two bytes, with a programmable address register. When a byte is accepted, the block drives the acknowledge bit itself and places the byte in a one-byte receive buffer for a host.

The host works through a few strobes:
- a buffer read, which empties the buffer;
- an address-register write;
- an overflow clear.

A two-bit mode input picks 7-bit or 10-bit addressing. The same input decides whether bus Start and Stop conditions also raise the interrupt. In 10-bit addressing, after each address byte the block holds SCL low. It releases SCL only when the host rewrites the address register with the other half of the address. Both pads are open-drain, so each is modelled as an active-high drive-low enable.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset, all of these are 0: `buf_full`, `ovf`, `ua`, `irq`, `sda_oe` and `scl_oe`.
- R2: Bus activity is ignored in these cases, with no acknowledge and no change to the buffer:
  - `en` is 0;
  - no Start has been seen since enable;
  - a Stop has been seen and no new Start has followed it.
- R3: With `mode[0]`=0 (7-bit), a first byte whose bits [7:1] equal address-register bits [7:1] is handled as follows:
  - SDA is pulled low during the 9th clock;
  - the whole byte, including bit 0, goes into `rx_data` and `buf_full` is set;
  - `irq` pulses for one cycle.
  A first byte that does not match gets no acknowledge and no `irq`, and `buf_full` stays 0.
- R4: After a matched address with bit 0 = 0 (write), every later data byte is acknowledged and loaded, and each one raises `irq`.
- R5: If `buf_full` or `ovf` is already 1 when an otherwise accepted byte completes:
  - the byte gets no acknowledge;
  - `rx_data` is not reloaded;
  - `irq` still pulses;
  - `ovf` becomes 1 if `buf_full` was 1.
- R6: A `buf_rd` pulse clears `buf_full` on the next clock. `ovf` stays set until an `ovf_clr` pulse.
- R7: With `mode[0]`=1 (10-bit), a first byte equal to binary 11110, then address-register bits [2:1], then 0 is acknowledged and loaded. On the 9th falling edge the block then sets `ua` and holds SCL low (`scl_oe`=1). A write to the address register clears `ua` and releases SCL. A first byte with different bits [2:1] gets no acknowledge.
- R8: In 10-bit mode, the second byte must equal all 8 address-register bits. When it matches, it is acknowledged and loaded, and `ua` and the SCL hold are set again. After the next address write, data bytes are received as in R4.
- R9: After a full 10-bit match, a Repeated Start followed by the high byte with bit 0 = 1 is acknowledged. That byte sets `buf_full` and `irq` and leaves `ua` at 0.
- R10: With `mode[1]`=1, each Start and each Stop pulses `irq`. With `mode[1]`=0 they do not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| mode | input | 2 | Bit 0: 10-bit addressing; bit 1: interrupt on Start/Stop |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| addr_wr | input | 1 | Address-register write strobe |
| addr_wdata | input | 8 | Address-register write value |
| buf_rd | input | 1 | Receive-buffer read strobe |
| ovf_clr | input | 1 | Overflow clear strobe |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| irq | output | 1 | One-cycle interrupt pulse |
| ua | output | 1 | Host must update the address register |

## Verification
Both bus lines pass through a two-flop synchronizer and an edge register, and the control outputs are registered. As a result, `sda_oe`, `rx_data` and `buf_full` change about four system cycles after the 8th SCL falling edge reaches the pins. The `irq` pulse and the `ua`/`scl_oe` hold follow about four cycles after the 9th falling edge. The bench model of the bus master waits ten cycles in every quarter of a bit before it moves a line or samples the acknowledge, and it reads the outputs on falling clock edges. The host strobes `buf_rd`, `ovf_clr` and `addr_wr` take effect on the next rising edge, and they are checked at the following falling edge. Interrupt pulses are counted by an edge counter, so each check compares the count before and after a whole bus event.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_LO,
    PH_DATA,
    PH_SKIP
  } rx_phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] cur;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  // one synchronizer chain per bus line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign cur[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end

  assign scl_lvl   = cur[0];
  assign scl_rise  = cur[0] & ~prev[0];
  assign scl_fall  = ~cur[0] & prev[0];
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = cur[0] & prev[0] & ~cur[1] & prev[1];
  assign stop_det  = cur[0] & prev[0] & cur[1] & ~prev[1];
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (shift_en) begin
      data  <= {data[BYTE_W-2:0], bit_in};
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] sh_data,
  input  logic [CNT_W-1:0]  sh_cnt,
  output logic              sh_en,
  output logic              sh_clr,
  input  logic              addr_wr,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq,
  output logic              ua,
  output logic              sda_oe,
  output logic              scl_oe
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  rx_phase_t         phase_q, nxt_q, nxt_c;
  logic [BYTE_W-1:0] addr_q, rx_q;
  logic              in_ack_q, ua_due_q, m10_q;
  logic              bf_q, ovf_q, irq_q, ua_q, sda_oe_q;
  logic              active, byte_done, ack_end, match, room, ua_c, set_m10;
  logic              hi_ok;

  assign active    = (phase_q == PH_ADDR) || (phase_q == PH_ADDR_LO) || (phase_q == PH_DATA);
  assign sh_en     = en && active && !in_ack_q && scl_rise && (sh_cnt < LAST_BIT);
  assign byte_done = en && active && !in_ack_q && scl_fall && (sh_cnt == LAST_BIT);
  assign ack_end   = en && in_ack_q && scl_fall;
  assign sh_clr    = !en || start_det || stop_det || ack_end;
  assign room      = !bf_q && !ovf_q;
  assign hi_ok     = (sh_data[7:3] == TEN_BIT_TAG) && (sh_data[2:1] == addr_q[2:1]);

  always_comb begin
    match   = 1'b0;
    nxt_c   = PH_SKIP;
    ua_c    = 1'b0;
    set_m10 = 1'b0;
    case (phase_q)
      PH_ADDR: begin
        if (mode[0]) begin
          match = hi_ok && (m10_q || !sh_data[0]);
          if (m10_q) begin
            nxt_c = sh_data[0] ? PH_SKIP : PH_DATA;
          end else begin
            nxt_c = PH_ADDR_LO;
            ua_c  = 1'b1;
          end
        end else begin
          match = (sh_data[7:1] == addr_q[7:1]);
          nxt_c = sh_data[0] ? PH_SKIP : PH_DATA;
        end
      end
      PH_ADDR_LO: begin
        match   = (sh_data == addr_q);
        nxt_c   = PH_DATA;
        ua_c    = 1'b1;
        set_m10 = 1'b1;
      end
      PH_DATA: begin
        match = 1'b1;
        nxt_c = PH_DATA;
      end
      default: begin
        match = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      nxt_q    <= PH_IDLE;
      addr_q   <= RESET_ADDR;
      rx_q     <= '0;
      in_ack_q <= 1'b0;
      ua_due_q <= 1'b0;
      m10_q    <= 1'b0;
      bf_q     <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
      ua_q     <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (buf_rd)  bf_q  <= 1'b0;
      if (ovf_clr) ovf_q <= 1'b0;
      if (addr_wr) begin
        addr_q <= addr_wdata;
        ua_q   <= 1'b0;
      end
      if (!en) begin
        phase_q  <= PH_IDLE;
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
        ua_q     <= 1'b0;
        m10_q    <= 1'b0;
      end else if (stop_det) begin
        phase_q  <= PH_IDLE;
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
        m10_q    <= 1'b0;
        irq_q    <= mode[1];
      end else if (start_det) begin
        phase_q  <= PH_ADDR;
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
        irq_q    <= mode[1];
      end else if (byte_done) begin
        if (!match) begin
          phase_q <= PH_SKIP;
        end else begin
          in_ack_q <= 1'b1;
          if (room) begin
            sda_oe_q <= 1'b1;
            rx_q     <= sh_data;
            bf_q     <= 1'b1;
            nxt_q    <= nxt_c;
            ua_due_q <= ua_c;
            if (set_m10) m10_q <= 1'b1;
          end else begin
            nxt_q    <= PH_SKIP;
            ua_due_q <= 1'b0;
            if (bf_q) ovf_q <= 1'b1;
          end
        end
      end else if (ack_end) begin
        in_ack_q <= 1'b0;
        sda_oe_q <= 1'b0;
        irq_q    <= 1'b1;
        phase_q  <= nxt_q;
        if (ua_due_q) ua_q <= 1'b1;
      end
    end
  end

  assign rx_data  = rx_q;
  assign buf_full = bf_q;
  assign ovf      = ovf_q;
  assign irq      = irq_q;
  assign ua       = ua_q;
  assign sda_oe   = sda_oe_q;
  assign scl_oe   = ua_q;
endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx
  import i2c_rx_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RESET_ADDR  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              addr_wr,
  input  logic [BYTE_W-1:0] addr_wdata,
  input  logic              buf_rd,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] rx_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq,
  output logic              ua
);
  logic              scl_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              sh_en, sh_clr;
  logic [BYTE_W-1:0] sh_data;
  logic [CNT_W-1:0]  sh_cnt;
  logic              sda_lvl;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // the bit is taken on the synchronized SDA at the SCL rising edge
  assign sda_lvl = u_sync.cur[1];

  i2c_byte_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (sh_clr),
    .shift_en (sh_en),
    .bit_in   (sda_lvl),
    .data     (sh_data),
    .count    (sh_cnt)
  );

  i2c_rx_ctrl #(.RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .mode       (mode),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sh_data    (sh_data),
    .sh_cnt     (sh_cnt),
    .sh_en      (sh_en),
    .sh_clr     (sh_clr),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .buf_rd     (buf_rd),
    .ovf_clr    (ovf_clr),
    .rx_data    (rx_data),
    .buf_full   (buf_full),
    .ovf        (ovf),
    .irq        (irq),
    .ua         (ua),
    .sda_oe     (sda_oe),
    .scl_oe     (scl_oe)
  );

  logic unused_lvl;
  assign unused_lvl = scl_lvl;
endmodule

// File: rtl/i2c_addr_rx_chk.sv
module i2c_addr_rx_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic addr_wr,
  input logic buf_rd,
  input logic ovf_clr,
  input logic sda_oe,
  input logic buf_full,
  input logic ovf,
  input logic irq,
  input logic ua
);
  // R3: an acknowledge begins only together with a fresh buffer load
  p_ack_loads_buf_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $rose(buf_full));

  // R5: overflow only rises when the buffer was already full
  p_ovf_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(buf_full));

  // R6: overflow holds until an explicit clear
  p_no_overflow_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  // R6: buffer-full only drops after a read strobe
  p_bf_clear_by_read_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_full) |-> $past(buf_rd));

  // R7: the update flag drops only on an address write or disable
  p_ua_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ua) |-> ($past(addr_wr) || !$past(en)));

  // R10: interrupts are single-cycle pulses
  p_irq_single_r10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind i2c_addr_rx i2c_addr_rx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .addr_wr  (addr_wr),
  .buf_rd   (buf_rd),
  .ovf_clr  (ovf_clr),
  .sda_oe   (sda_oe),
  .buf_full (buf_full),
  .ovf      (ovf),
  .irq      (irq),
  .ua       (ua)
);

// File: tb/i2c_addr_rx_bench.sv
module i2c_addr_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int NVEC       = 7;
  // {address register, first byte, expected acknowledge}, 7-bit mode
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h84, 8'h84, 1'b1},
    {8'h84, 8'h85, 1'b1},
    {8'h84, 8'h86, 1'b0},
    {8'h20, 8'h20, 1'b1},
    {8'h20, 8'h21, 1'b1},
    {8'h20, 8'hA0, 1'b0},
    {8'hFE, 8'hFF, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_oe, sda_oe;
  logic       addr_wr = 1'b0, buf_rd = 1'b0, ovf_clr = 1'b0;
  logic [7:0] addr_wdata = 8'h00;
  logic [7:0] rx_data;
  logic       buf_full, ovf, irq, ua;
  logic       scl_line, sda_line;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;
  int cyc = 0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_addr_rx u_i2c_addr_rx (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .mode       (mode),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .buf_rd     (buf_rd),
    .ovf_clr    (ovf_clr),
    .rx_data    (rx_data),
    .buf_full   (buf_full),
    .ovf        (ovf),
    .irq        (irq),
    .ua         (ua)
  );

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    do @(negedge clk); while (scl_line !== 1'b1);
    wait_q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1;
    wait_q();
    scl_up();
    sda_m = 1'b0;
    wait_q();
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0;
    wait_q();
    scl_up();
    sda_m = 1'b1;
    wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      wait_q();
      scl_up();
      scl_m = 1'b0;
      wait_q();
    end
    sda_m = 1'b1;
    wait_q();
    scl_m = 1'b1;
    do @(negedge clk); while (scl_line !== 1'b1);
    repeat (QTR / 2) @(negedge clk);
    ack = ~sda_line;
    repeat (QTR / 2) @(negedge clk);
    scl_m = 1'b0;
    wait_q();
  endtask

  task automatic host_addr(input logic [7:0] v);
    @(negedge clk);
    addr_wr = 1'b1;
    addr_wdata = v;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk);
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
  endtask

  initial begin
    logic ack;
    int   c0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 buf_full", buf_full, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 ua", ua, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);

    // R2: disabled block ignores a full transaction
    host_addr(8'h84);
    bus_start();
    send_byte(8'h84, ack);
    bus_stop();
    chk("R2 disabled ack", ack, 0);
    chk("R2 disabled bf", buf_full, 0);

    en = 1'b1;
    repeat (4) @(negedge clk);
    // R2: byte with no preceding Start
    send_byte(8'h84, ack);
    chk("R2 no start ack", ack, 0);
    chk("R2 no start bf", buf_full, 0);
    bus_stop();

    // R3 vectors, with R10 check that Start/Stop give no interrupt in mode 0
    for (int v = 0; v < NVEC; v++) begin
      host_addr(VEC[v][16:9]);
      c0 = irq_cnt;
      bus_start();
      send_byte(VEC[v][8:1], ack);
      bus_stop();
      chk($sformatf("R3 vec%0d ack", v), ack, VEC[v][0]);
      chk($sformatf("R3 vec%0d bf", v), buf_full, VEC[v][0]);
      chk($sformatf("R3 R10 vec%0d irq", v), irq_cnt - c0, VEC[v][0] ? 1 : 0);
      if (VEC[v][0]) begin
        chk($sformatf("R3 vec%0d data", v), rx_data, VEC[v][8:1]);
        host_read();
      end
    end

    // R4: data bytes after a matched write address
    host_addr(8'h84);
    bus_start();
    send_byte(8'h84, ack);
    host_read();
    c0 = irq_cnt;
    send_byte(8'h5A, ack);
    chk("R4 ack1", ack, 1);
    chk("R4 data1", rx_data, 8'h5A);
    chk("R4 irq1", irq_cnt - c0, 1);
    host_read();
    send_byte(8'hC3, ack);
    chk("R4 ack2", ack, 1);
    chk("R4 data2", rx_data, 8'hC3);
    host_read();
    bus_stop();

    // R5 / R6: unread buffer blocks the next byte
    bus_start();
    send_byte(8'h84, ack);
    c0 = irq_cnt;
    send_byte(8'h11, ack);
    chk("R5 full nack", ack, 0);
    chk("R5 ovf set", ovf, 1);
    chk("R5 data kept", rx_data, 8'h84);
    chk("R5 irq still", irq_cnt - c0, 1);
    bus_stop();
    @(negedge clk);
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    chk("R6 bf cleared", buf_full, 0);
    chk("R6 ovf stays", ovf, 1);
    c0 = irq_cnt;
    bus_start();
    send_byte(8'h84, ack);
    bus_stop();
    chk("R5 ovf nack", ack, 0);
    chk("R5 ovf no load", buf_full, 0);
    chk("R5 ovf irq", irq_cnt - c0, 1);
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R6 ovf cleared", ovf, 0);
    bus_start();
    send_byte(8'h84, ack);
    bus_stop();
    chk("R6 ack after clear", ack, 1);
    host_read();

    // R7 / R8 / R9: 10-bit address 0x2B5 (high byte 0xF4, low 0xB5)
    mode = 2'b01;
    host_addr(8'hF4);
    bus_start();
    send_byte(8'hF4, ack);
    chk("R7 hi ack", ack, 1);
    chk("R7 hi data", rx_data, 8'hF4);
    chk("R7 ua set", ua, 1);
    chk("R7 scl held", scl_oe, 1);
    host_read();
    repeat (30) @(negedge clk);
    chk("R7 line low", scl_line, 0);
    host_addr(8'hB5);
    chk("R7 ua cleared", ua, 0);
    chk("R7 scl released", scl_oe, 0);
    send_byte(8'hB5, ack);
    chk("R8 lo ack", ack, 1);
    chk("R8 lo data", rx_data, 8'hB5);
    chk("R8 ua set", ua, 1);
    host_read();
    host_addr(8'hF4);
    send_byte(8'h77, ack);
    chk("R8 data ack", ack, 1);
    chk("R8 data", rx_data, 8'h77);
    chk("R8 ua idle", ua, 0);
    host_read();
    c0 = irq_cnt;
    bus_start();
    send_byte(8'hF5, ack);
    chk("R9 ack", ack, 1);
    chk("R9 bf", buf_full, 1);
    chk("R9 data", rx_data, 8'hF5);
    chk("R9 no ua", ua, 0);
    chk("R9 irq", irq_cnt - c0, 1);
    host_read();
    bus_stop();
    bus_start();
    send_byte(8'hF6, ack);
    bus_stop();
    chk("R7 hi mismatch", ack, 0);
    chk("R7 mismatch ua", ua, 0);

    // R10: Start/Stop interrupts
    mode = 2'b10;
    host_addr(8'h84);
    c0 = irq_cnt;
    bus_start();
    chk("R10 start irq", irq_cnt - c0, 1);
    send_byte(8'h84, ack);
    chk("R10 byte irq", irq_cnt - c0, 2);
    host_read();
    bus_stop();
    chk("R10 stop irq", irq_cnt - c0, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule